// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block is the translation store of a memory management unit. It has 48 fully associative entries. Each entry maps a pair of adjacent virtual pages, one even and one odd, so 96 pages can be mapped at once. Each entry sets its own page size, from 4 KB up to 16 MB in powers of four. A lookup presents a 32-bit virtual address and an 8-bit address space tag. One cycle later the block answers with one of three results: hit, miss, or invalid-page fault. A hit carries a 36-bit physical address and the cache-policy attribute bits of the selected page.

Software fills the buffer through a single write port. The target slot is either an explicit index or the current value of a free-running replacement pointer. A programmable lock count keeps the lowest slots out of reach of that pointer. Critical mappings placed there therefore survive random refills.

Top module: `tlb_lockable`

## Requirements
- R1: While reset is active and after it is released, `rand_idx` reads 47 and the lock count is 0. All responses are low. Any lookup made before the first write misses (hit=0, fault=0).
- R2: A lookup driven with `lk_valid` in one cycle produces `rsp_valid`=1 with its result in the next cycle. `rsp_valid` is 0 in a cycle that follows no request.
- R3: An entry matches only if its address space tag equals `lk_asid`, unless the entry's global flag is set. With the global flag set, the tag is not compared.
- R4: `wr_mask` is 12 bits. Its legal values are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF, giving page sizes 4K·4^k with k = ones/2. Mask bit j removes virtual address bit 13+j from the compare. The same bit j takes physical address bit 12+j from the virtual address instead of the frame number. Physical bits 11:0 always come from the virtual address.
- R5: The even or odd half of a matched entry is chosen by virtual address bit 12+2k (bit 12 for 4K pages, bit 24 for 16M pages). A 1 selects the odd half.
- R6: A match on a half whose valid bit is 0 gives `rsp_fault`=1 and `rsp_hit`=0, with `rsp_index` naming the entry. `rsp_hit` and `rsp_fault` are never both 1.
- R7: A lookup that matches no entry gives `rsp_hit`=0, `rsp_fault`=0, and zero on `rsp_pa`, `rsp_attr` and `rsp_index`.
- R8: When no lock write occurs, `rand_idx` decrements by one each clock. In the cycle after it equals the lock count W, it reloads 47. It never reads below W.
- R9: A lock write loads W and reloads `rand_idx` to 47 in the next cycle. A requested count of 48 or more is held at 47.
- R10: With `wr_random`=1, a write goes to the slot shown on `rand_idx` in that cycle, and `wr_index` is ignored. With `wr_random`=0, the write goes to `wr_index`. An index of 48 or more writes nothing. A write is visible to lookups issued in the following cycle.
- R11: When several entries match, the lowest-numbered entry supplies the result.
- R12: On a hit, `rsp_attr` returns the 3 attribute bits stored with the selected half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address space tag of the lookup |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Valid translation found |
| rsp_fault | output | 1 | Matched half is invalid |
| rsp_index | output | 6 | Entry that matched |
| rsp_pa | output | 36 | Physical address |
| rsp_attr | output | 3 | Cache-policy bits of the page |
| wr_en | input | 1 | Write an entry |
| wr_random | input | 1 | Use the replacement pointer as the target |
| wr_index | input | 6 | Explicit target slot |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31:13) |
| wr_asid | input | 8 | Address space tag of the entry |
| wr_global | input | 1 | Ignore the tag in compares |
| wr_mask | input | 12 | Page size mask |
| wr_pfn_even | input | 24 | Frame number of the even page |
| wr_attr_even | input | 3 | Attributes of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_pfn_odd | input | 24 | Frame number of the odd page |
| wr_attr_odd | input | 3 | Attributes of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| lock_we | input | 1 | Load a new lock count |
| lock_count | input | 6 | Number of locked low slots |
| rand_idx | output | 6 | Current replacement pointer |

## Verification
A corrupted replacement pointer shows on `rand_idx` within one clock. It appears as a step other than minus one, a reload to the wrong value, or a dip below the lock floor. A wrong stored entry or a wrong compare mask does not show until a lookup touches that entry. The response then appears one cycle after the request, as a wrong hit/miss/fault choice, a wrong index, or physical address bits taken from the wrong source. Directed lookups that straddle page-size boundaries and the odd/even select bit expose those faults on the first request that reaches them.

// File: rtl/tlb_lockable_pkg.sv
package tlb_lockable_pkg;
    parameter int ENTRIES = 48;
    parameter int IDX_W   = $clog2(ENTRIES);
    parameter int VA_W    = 32;
    parameter int PA_W    = 36;
    parameter int OFF_W   = 12;
    parameter int ASID_W  = 8;
    parameter int MASK_W  = 12;
    parameter int ATTR_W  = 3;
    parameter int VPN2_W  = VA_W - OFF_W - 1;
    parameter int PFN_W   = PA_W - OFF_W;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              valid;
    } half_t;

    typedef struct packed {
        logic              loaded;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              global_f;
        logic [MASK_W-1:0] mask;
        half_t             even;
        half_t             odd;
    } entry_t;
endpackage

// File: rtl/tlb_cam_cell.sv
module tlb_cam_cell
    import tlb_lockable_pkg::*;
(
    input  entry_t            ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic              match,
    output half_t             half,
    output logic [PA_W-1:0]   pa
);
    localparam int HI_W = PFN_W - MASK_W;

    logic [VPN2_W-1:0] cmp_mask;
    logic              odd_sel;

    always_comb begin
        cmp_mask = {{(VPN2_W-MASK_W){1'b0}}, ent.mask};
        match    = ent.loaded
                 && ((va[VA_W-1:OFF_W+1] & ~cmp_mask) == (ent.vpn2 & ~cmp_mask))
                 && (ent.global_f || (asid == ent.asid));

        odd_sel = va[OFF_W];
        for (int k = 0; k <= MASK_W; k++) begin
            if ($countones(ent.mask) == k) odd_sel = va[OFF_W + k];
        end

        half = odd_sel ? ent.odd : ent.even;

        pa[OFF_W-1:0]              = va[OFF_W-1:0];
        pa[OFF_W+MASK_W-1:OFF_W]   = (half.pfn[MASK_W-1:0] & ~ent.mask)
                                   | (va[OFF_W+MASK_W-1:OFF_W] & ent.mask);
        pa[PA_W-1:OFF_W+MASK_W]    = half.pfn[PFN_W-1:PFN_W-HI_W];
    end
endmodule

// File: rtl/tlb_rand_ptr.sv
module tlb_rand_ptr
    import tlb_lockable_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_val,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] floor_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] floor_v;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_we) begin
            st_d.floor_v = (lock_val > TOP) ? TOP : lock_val;
            st_d.idx     = TOP;
        end else if (st_q.idx <= st_q.floor_v) begin
            st_d.idx = TOP;
        end else begin
            st_d.idx = st_q.idx - IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx     <= TOP;
            st_q.floor_v <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx     = st_q.idx;
    assign floor_o = st_q.floor_v;
endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
    import tlb_lockable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [ATTR_W-1:0] wr_attr_even,
    input  logic              wr_valid_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic [ATTR_W-1:0] wr_attr_odd,
    input  logic              wr_valid_odd,
    input  logic              lock_we,
    input  logic [IDX_W-1:0]  lock_count,
    output logic [IDX_W-1:0]  rand_idx
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 valid;
        logic                 hit;
        logic                 fault;
        logic [IDX_W-1:0]     index;
        logic [PA_W-1:0]      pa;
        logic [ATTR_W-1:0]    attr;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] lock_floor;
    logic             cell_match [ENTRIES];
    half_t            cell_half  [ENTRIES];
    logic [PA_W-1:0]  cell_pa    [ENTRIES];

    tlb_rand_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (lock_we),
        .lock_val (lock_count),
        .idx      (rand_idx),
        .floor_o  (lock_floor)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        tlb_cam_cell u_cell (
            .ent   (st_q.ent[g]),
            .va    (lk_va),
            .asid  (lk_asid),
            .match (cell_match[g]),
            .half  (cell_half[g]),
            .pa    (cell_pa[g])
        );
    end

    always_comb begin
        logic [IDX_W-1:0] tgt;
        entry_t           new_ent;
        logic             found;
        logic [IDX_W-1:0] pick_idx;
        half_t            pick_half;
        logic [PA_W-1:0]  pick_pa;

        st_d = st_q;

        new_ent.loaded     = 1'b1;
        new_ent.vpn2       = wr_vpn2;
        new_ent.asid       = wr_asid;
        new_ent.global_f   = wr_global;
        new_ent.mask       = wr_mask;
        new_ent.even.pfn   = wr_pfn_even;
        new_ent.even.attr  = wr_attr_even;
        new_ent.even.valid = wr_valid_even;
        new_ent.odd.pfn    = wr_pfn_odd;
        new_ent.odd.attr   = wr_attr_odd;
        new_ent.odd.valid  = wr_valid_odd;

        tgt = wr_random ? rand_idx : wr_index;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (tgt == IDX_W'(i))) st_d.ent[i] = new_ent;
        end

        found     = 1'b0;
        pick_idx  = '0;
        pick_half = '0;
        pick_pa   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cell_match[i]) begin
                found     = 1'b1;
                pick_idx  = IDX_W'(i);
                pick_half = cell_half[i];
                pick_pa   = cell_pa[i];
            end
        end

        st_d.valid = lk_valid;
        st_d.hit   = lk_valid && found && pick_half.valid;
        st_d.fault = lk_valid && found && !pick_half.valid;
        st_d.index = (lk_valid && found) ? pick_idx : '0;
        st_d.pa    = (lk_valid && found && pick_half.valid) ? pick_pa : '0;
        st_d.attr  = (lk_valid && found && pick_half.valid) ? pick_half.attr : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_hit   = st_q.hit;
    assign rsp_fault = st_q.fault;
    assign rsp_index = st_q.index;
    assign rsp_pa    = st_q.pa;
    assign rsp_attr  = st_q.attr;
endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk
    import tlb_lockable_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lock_we,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic [IDX_W-1:0] rand_idx,
    input logic [IDX_W-1:0] lock_floor
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r6_hit_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    a_r2_result_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_fault) |-> rsp_valid);

    a_r8_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (rand_idx >= lock_floor) && (rand_idx <= TOP));

    a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_we && (rand_idx > lock_floor)) |=> (rand_idx == $past(rand_idx) - IDX_W'(1)));

    a_r8_wrap_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_we && (rand_idx == lock_floor)) |=> (rand_idx == TOP));

    a_r9_lock_reload: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> (rand_idx == TOP));
endmodule

bind tlb_lockable tlb_lockable_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lock_we    (lock_we),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rand_idx   (rand_idx),
    .lock_floor (lock_floor)
);

// File: tb/tlb_lockable_test.sv
`timescale 1ns/1ps
module tlb_lockable_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [5:0]  rsp_index;
    logic [35:0] rsp_pa;
    logic [2:0]  rsp_attr;
    logic        wr_en = 1'b0, wr_random = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [11:0] wr_mask = '0;
    logic [23:0] wr_pfn_even = '0, wr_pfn_odd = '0;
    logic [2:0]  wr_attr_even = '0, wr_attr_odd = '0;
    logic        wr_valid_even = 1'b0, wr_valid_odd = 1'b0;
    logic        lock_we = 1'b0;
    logic [5:0]  lock_count = '0;
    logic [5:0]  rand_idx;

    int n_checks = 0;
    int n_fail   = 0;
    logic [5:0] last_rand;

    always #4 clk = ~clk;

    tlb_lockable uut (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic rnd, input logic [5:0] idx, input logic [18:0] vpn2,
                       input logic [7:0] asid, input logic g, input logic [11:0] mask,
                       input logic [23:0] pe, input logic [2:0] ae, input logic ve,
                       input logic [23:0] po, input logic [2:0] ao, input logic vo);
        @(negedge clk);
        last_rand = rand_idx;
        wr_en = 1'b1; wr_random = rnd; wr_index = idx; wr_vpn2 = vpn2;
        wr_asid = asid; wr_global = g; wr_mask = mask;
        wr_pfn_even = pe; wr_attr_even = ae; wr_valid_even = ve;
        wr_pfn_odd = po; wr_attr_odd = ao; wr_valid_odd = vo;
        @(negedge clk);
        wr_en = 1'b0; wr_random = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid);
        if (lk_valid === 1'b0) @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "rand_idx in reset", 64'(rand_idx), 64'd47);
        check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        look(32'h0000_0000, 8'd0);
        check("R1", "miss before writes hit", 64'(rsp_hit), 64'd0);
        check("R1", "miss before writes fault", 64'(rsp_fault), 64'd0);
        check("R2", "rsp_valid after request", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        check("R2", "rsp_valid with no request", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_basic_asid();
        put(1'b0, 6'd7, 19'h00012, 8'd5, 1'b0, 12'h000,
            24'h0ABCDE, 3'd2, 1'b1, 24'h012345, 3'd5, 1'b1);
        look({19'h00012, 1'b0, 12'h123}, 8'd5);
        check("R5", "even hit", 64'(rsp_hit), 64'd1);
        check("R4", "even pa", 64'(rsp_pa), 64'h0ABCDE123);
        check("R12", "even attr", 64'(rsp_attr), 64'd2);
        check("R6", "index", 64'(rsp_index), 64'd7);
        look({19'h00012, 1'b1, 12'h456}, 8'd5);
        check("R5", "odd pa", 64'(rsp_pa), 64'h012345456);
        check("R12", "odd attr", 64'(rsp_attr), 64'd5);
        look({19'h00012, 1'b0, 12'h123}, 8'd6);
        check("R3", "tag mismatch misses", 64'(rsp_hit), 64'd0);
        check("R7", "miss pa zero", 64'(rsp_pa), 64'd0);
        check("R7", "miss index zero", 64'(rsp_index), 64'd0);
        put(1'b0, 6'd8, 19'h00020, 8'd5, 1'b1, 12'h000,
            24'h000111, 3'd1, 1'b1, 24'h000222, 3'd1, 1'b1);
        look({19'h00020, 1'b0, 12'h000}, 8'd9);
        check("R3", "global ignores tag", 64'(rsp_hit), 64'd1);
    endtask

    task automatic t_page_size();
        put(1'b0, 6'd9, 19'h00040, 8'd1, 1'b0, 12'h00F,
            24'h000550, 3'd3, 1'b1, 24'h000770, 3'd4, 1'b1);
        look(32'h0008_ABCD, 8'd1);
        check("R4", "64K even pa", 64'(rsp_pa), 64'h00055ABCD);
        look(32'h0009_ABCD, 8'd1);
        check("R5", "64K odd via bit 16", 64'(rsp_pa), 64'h00077ABCD);
        look(32'h000A_0000, 8'd1);
        check("R4", "outside 64K pair misses", 64'(rsp_hit), 64'd0);
        put(1'b0, 6'd11, 19'h60000, 8'd1, 1'b0, 12'hFFF,
            24'h123000, 3'd0, 1'b1, 24'hABC000, 3'd6, 1'b1);
        look(32'hC123_4567, 8'd1);
        check("R5", "16M odd via bit 24", 64'(rsp_pa), 64'hABC234567);
        check("R12", "16M odd attr", 64'(rsp_attr), 64'd6);
    endtask

    task automatic t_invalid();
        put(1'b0, 6'd12, 19'h00100, 8'd2, 1'b0, 12'h000,
            24'h000AAA, 3'd1, 1'b1, 24'h000BBB, 3'd1, 1'b0);
        look({19'h00100, 1'b1, 12'h010}, 8'd2);
        check("R6", "invalid half faults", 64'(rsp_fault), 64'd1);
        check("R6", "invalid half no hit", 64'(rsp_hit), 64'd0);
        check("R6", "fault index", 64'(rsp_index), 64'd12);
    endtask

    task automatic t_priority();
        put(1'b0, 6'd10, 19'h00200, 8'd3, 1'b0, 12'h000,
            24'h000010, 3'd1, 1'b1, 24'h000010, 3'd1, 1'b1);
        put(1'b0, 6'd3, 19'h00200, 8'd3, 1'b0, 12'h000,
            24'h000030, 3'd1, 1'b1, 24'h000030, 3'd1, 1'b1);
        look({19'h00200, 1'b0, 12'h000}, 8'd3);
        check("R11", "lowest index wins", 64'(rsp_index), 64'd3);
        check("R11", "lowest index pa", 64'(rsp_pa), 64'h000030000);
    endtask

    task automatic t_bad_index();
        put(1'b0, 6'd50, 19'h00300, 8'd3, 1'b1, 12'h000,
            24'h000099, 3'd1, 1'b1, 24'h000099, 3'd1, 1'b1);
        look({19'h00300, 1'b0, 12'h000}, 8'd3);
        check("R10", "index 50 writes nothing", 64'(rsp_hit | rsp_fault), 64'd0);
    endtask

    task automatic t_rand_write();
        put(1'b1, 6'd1, 19'h00400, 8'd4, 1'b0, 12'h000,
            24'h000444, 3'd7, 1'b1, 24'h000444, 3'd7, 1'b1);
        look({19'h00400, 1'b0, 12'h000}, 8'd4);
        check("R10", "random write slot", 64'(rsp_index), 64'(last_rand));
        check("R10", "random write hit", 64'(rsp_hit), 64'd1);
    endtask

    task automatic t_lock();
        logic [5:0] prev;
        @(negedge clk);
        lock_we = 1'b1; lock_count = 6'd5;
        @(negedge clk);
        lock_we = 1'b0;
        check("R9", "reload after lock write", 64'(rand_idx), 64'd47);
        prev = rand_idx;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rand_idx < 6'd5) check("R8", "below floor", 64'(rand_idx), 64'd5);
            check("R8", "pointer step", 64'(rand_idx),
                  (prev == 6'd5) ? 64'd47 : 64'(prev - 6'd1));
            prev = rand_idx;
        end
        lock_we = 1'b1; lock_count = 6'd60;
        @(negedge clk);
        lock_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "saturated lock holds 47", 64'(rand_idx), 64'd47);
        lock_we = 1'b1; lock_count = 6'd0;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic_asid();
        t_page_size();
        t_invalid();
        t_priority();
        t_bad_index();
        t_rand_write();
        t_lock();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule